// File: doc/BRIEF.md
# Synchronous Slave FIFO Burst Master

This block is the FPGA-side master of a synchronous slave FIFO port on a 16-bit shared bus. A typical partner is a USB bridge that exposes one FIFO toward the host and one from it. Words from a local valid/ready source are driven onto the bus and written with an active-low write strobe. Words the slave holds are read with an active-low output enable and read strobe, then handed to a local valid/ready sink. The strobe stays low for as long as a burst can move data, so full-rate mode carries one word per clock: 2 bytes per edge, or 96 MB/s at 48 MHz. A conservative mode carries one word on every other edge, for boards that cannot meet burst setup and hold.

The slave reports four active-low flags, all synchronous to the port clock. Each flag shows the slave's fill state as it stood before the previous rising edge, so it lags by one cycle. The near flags assert one word ahead of the true boundary. The master treats a near flag as one remaining transfer and counts the word it moved in the previous cycle against it. This lets a burst run right up to the boundary without overrunning the slave or reading it dry.

Back-pressure rules: `s_ready` is high exactly in the cycles in which the write strobe is low, and it may depend on `s_valid`. The source may drop `s_valid` at any time, and the write strobe then stays high. The sink side is a single output register: `m_valid` with `m_data` holds until `m_ready` is seen, and no read is issued while that register is full and not being emptied.

Top module: `sfifo_burst_master`

## Requirements
- R1: While reset is low, and in the first cycle after it, both strobes and the output enable are high (inactive), `bus_drive` is 0 and `m_valid` is 0.
- R2: In full-rate mode (`half_rate`=0), with the source valid and room in the slave, `wr_stb_n` stays low every cycle of the burst and one word per clock is written, in source order, with `bus_wdata` equal to `s_data`.
- R3: In full-rate mode, with data in the slave and the sink ready, `oe_n` and `rd_stb_n` stay low for the burst and one word per clock is read; `m_data` delivers the words in slave order, one cycle after the read edge.
- R4: A write is issued only if `near_full_n` is 1, or if `full_n` is 1 and no write was issued in the previous cycle. The slave therefore never receives a word while it holds its full depth, and it can still be filled to its last slot.
- R5: A read is issued only if `near_empty_n` is 1, or if `empty_n` is 1 and no read was issued in the previous cycle. The slave is therefore never read while empty, and a lone final word is still fetched.
- R6: With `half_rate`=1 (held for at least one cycle), no strobe is low in two consecutive cycles.
- R7: `bus_drive` never rises in a cycle that directly follows a cycle with `oe_n` low, so at least one turnaround cycle separates a read burst from a write burst.
- R8: `bus_drive`=1 never coincides with `oe_n`=0, and the write and read strobes are never low in the same cycle.
- R9: `s_ready` equals the inverse of `wr_stb_n`. A write happens only with `s_valid`=1 and `bus_drive`=1, and when the source is not valid the burst pauses with the strobe high.
- R10: Once `m_valid` is 1 with `m_ready` 0, `m_valid` stays 1 and `m_data` stays unchanged in the next cycle.
- R11: From idle, a write is chosen over a read when both can move. A running burst does not yield to the other direction while it can still transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; everything changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| half_rate | input | 1 | 1 selects the one-word-every-other-edge mode |
| s_valid | input | 1 | Local source has a word |
| s_ready | output | 1 | Source word taken this cycle |
| s_data | input | 16 | Local source word |
| m_valid | output | 1 | Sink word available |
| m_ready | input | 1 | Sink takes the word this cycle |
| m_data | output | 16 | Word read from the slave |
| bus_wdata | output | 16 | Bus value when driving |
| bus_drive | output | 1 | 1 enables the pad drivers of the shared bus |
| bus_rdata | input | 16 | Bus value from the pads |
| wr_stb_n | output | 1 | Active-low write strobe |
| rd_stb_n | output | 1 | Active-low read strobe |
| oe_n | output | 1 | Active-low slave output enable |
| full_n | input | 1 | Active-low: slave write FIFO full |
| near_full_n | input | 1 | Active-low: one free slot or fewer |
| empty_n | input | 1 | Active-low: slave read FIFO empty |
| near_empty_n | input | 1 | Active-low: one word or fewer |

## Verification
The bench builds the block with its default 16-bit word. It pairs it with a slave model only 8 words deep on each side, so the near and true flag boundaries come up within a few cycles of any slow drain or slow fill. The shallow depth brings the flag edge cases within reach: filling the last slot, reading a single trailing word, and the one-cycle flag lag during back-to-back bursts. All of these are met in both rate modes and under source gaps and random sink stalls.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_TURN  = 2'd3
  } sfm_state_e;
endpackage

// File: rtl/sfm_flag_credit.sv
// Decides whether one more transfer may be issued toward a flag boundary.
// The flags lag one edge; a near flag grants one word, which is consumed
// if a transfer was issued in the previous cycle.
module sfm_flag_credit (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic near_n,
  input  logic hard_n,
  output logic allow
);
  logic fired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= fire;
  end

  assign allow = near_n | (hard_n & ~fired_q);
endmodule

// File: rtl/sfm_pacer.sv
// Conservative mode: forbids a transfer in the cycle after one happened.
module sfm_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  input  logic fire_any,
  output logic slot_ok
);
  logic gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= half_rate & fire_any;
  end

  assign slot_ok = ~(half_rate & gap_q);
endmodule

// File: rtl/sfm_rx_stage.sv
// Output register for the sink stream.
module sfm_rx_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              space
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (cap) begin
      m_valid <= 1'b1;
      m_data  <= cap_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assign space = ~m_valid | m_ready;
endmodule

// File: rtl/sfm_burst_fsm.sv
module sfm_burst_fsm
  import sfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       can_wr,
  input  logic       can_rd,
  output sfm_state_e state
);
  sfm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (can_wr) nxt = ST_WRITE;
                else if (can_rd) nxt = ST_READ;
      ST_WRITE: if (!can_wr && can_rd) nxt = ST_IDLE;
      ST_READ:  if (!can_rd && can_wr) nxt = ST_TURN;
      ST_TURN:  nxt = can_wr ? ST_WRITE : ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sfifo_burst_master.sv
module sfifo_burst_master
  import sfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_rate,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_drive,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              wr_stb_n,
  output logic              rd_stb_n,
  output logic              oe_n,
  input  logic              full_n,
  input  logic              near_full_n,
  input  logic              empty_n,
  input  logic              near_empty_n
);
  sfm_state_e state;
  logic wr_allow, rd_allow, slot_ok, space;
  logic can_wr, can_rd, wr_fire, rd_fire;
  logic in_write, in_read;

  assign in_write = (state == ST_WRITE);
  assign in_read  = (state == ST_READ);
  assign can_wr   = s_valid & wr_allow;
  assign can_rd   = rd_allow & space;
  assign wr_fire  = in_write & can_wr & slot_ok;
  assign rd_fire  = in_read & can_rd & slot_ok;

  sfm_flag_credit u_wr_credit (
    .clk(clk), .rst_n(rst_n), .fire(wr_fire),
    .near_n(near_full_n), .hard_n(full_n), .allow(wr_allow)
  );

  sfm_flag_credit u_rd_credit (
    .clk(clk), .rst_n(rst_n), .fire(rd_fire),
    .near_n(near_empty_n), .hard_n(empty_n), .allow(rd_allow)
  );

  sfm_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
    .fire_any(wr_fire | rd_fire), .slot_ok(slot_ok)
  );

  sfm_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cap(rd_fire), .cap_data(bus_rdata),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .space(space)
  );

  sfm_burst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .can_wr(can_wr), .can_rd(can_rd), .state(state)
  );

  assign wr_stb_n  = ~wr_fire;
  assign rd_stb_n  = ~rd_fire;
  assign oe_n      = ~in_read;
  assign bus_drive = in_write;
  assign bus_wdata = s_data;
  assign s_ready   = wr_fire;
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              half_rate,
  input logic              s_valid,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              bus_drive,
  input logic              wr_stb_n,
  input logic              rd_stb_n,
  input logic              oe_n,
  input logic              full_n,
  input logic              near_full_n,
  input logic              empty_n,
  input logic              near_empty_n
);
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_stb_n && !rd_stb_n)); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_drive && !oe_n)); // R8
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && !$past(bus_drive)) |-> $past(oe_n)); // R7
  AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && $past(half_rate) && (!wr_stb_n || !rd_stb_n)) |-> ($past(wr_stb_n) && $past(rd_stb_n))); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb_n && !near_full_n) |-> (full_n && $past(wr_stb_n))); // R4
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb_n && !near_empty_n) |-> (empty_n && $past(rd_stb_n))); // R5
  AST_READ_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_n |-> !oe_n); // R3
  AST_WRITE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_n |-> (s_valid && bus_drive)); // R9
  AST_SINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R10
endmodule

bind sfifo_burst_master sfm_checker #(.DATA_W(DATA_W)) u_sfm_checker (
  .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .s_valid(s_valid),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .bus_drive(bus_drive),
  .wr_stb_n(wr_stb_n), .rd_stb_n(rd_stb_n), .oe_n(oe_n), .full_n(full_n),
  .near_full_n(near_full_n), .empty_n(empty_n), .near_empty_n(near_empty_n)
);

// File: tb/test_sfifo_burst_master.sv
module test_sfifo_burst_master;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_rate = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [15:0] s_data = '0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic [15:0] m_data;
  logic [15:0] bus_wdata;
  logic bus_drive;
  logic [15:0] bus_rdata = '0;
  logic wr_stb_n, rd_stb_n, oe_n;
  logic full_n = 1'b1, near_full_n = 1'b1, empty_n = 1'b0, near_empty_n = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfifo_burst_master i_sfifo_burst_master (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .bus_wdata(bus_wdata), .bus_drive(bus_drive), .bus_rdata(bus_rdata),
    .wr_stb_n(wr_stb_n), .rd_stb_n(rd_stb_n), .oe_n(oe_n),
    .full_n(full_n), .near_full_n(near_full_n),
    .empty_n(empty_n), .near_empty_n(near_empty_n)
  );

  int checks = 0;
  int failures = 0;

  logic [15:0] src_q[$];
  logic [15:0] wexp_q[$];
  logic [15:0] host_q[$];
  logic [15:0] rfifo_q[$];
  logic [15:0] rexp_q[$];

  int wcnt = 0, wcnt_lag = 0, rcnt_lag = 0, cyc = 0;
  int drain_per = 1, fill_per = 1, src_gap = 0, sink_rand = 0;
  int wr_streak = 0, max_wr_streak = 0, rd_streak = 0, max_rd_streak = 0;
  int max_wcnt = 0, reads_with_src = 0, first_wr = -1, last_wr = -1, n_wr = 0;
  bit prev_fire = 0, prev_half = 0, prev_drive = 0, prev_oe_n = 1;
  bit prev_mv = 0, prev_mr = 0;
  logic [15:0] prev_md = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_write(input logic [15:0] w);
    src_q.push_back(w);
    wexp_q.push_back(w);
  endtask

  task automatic push_read(input logic [15:0] w);
    host_q.push_back(w);
    rexp_q.push_back(w);
  endtask

  task automatic wait_drained(input string req, input int limit);
    int n = 0;
    while ((src_q.size() + wexp_q.size() + host_q.size() + rfifo_q.size() + rexp_q.size()) != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    check(n < limit, req, src_q.size() + rexp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_stats();
    max_wr_streak = 0; max_rd_streak = 0; max_wcnt = 0;
    reads_with_src = 0; first_wr = -1; last_wr = -1; n_wr = 0;
  endtask

  // Slave FIFO model and scoreboard monitor
  initial begin
    forever begin
      bit wr, rd;
      @(negedge clk);
      cyc++;
      full_n       = !(wcnt_lag >= DEPTH);
      near_full_n  = !(wcnt_lag >= DEPTH - 1);
      empty_n      = !(rcnt_lag == 0);
      near_empty_n = !(rcnt_lag <= 1);
      wcnt_lag = wcnt;
      rcnt_lag = rfifo_q.size();
      s_valid = (src_q.size() > 0) && !(src_gap != 0 && (cyc % 3) == 0);
      s_data  = (src_q.size() > 0) ? src_q[0] : 16'h0;
      m_ready = (sink_rand != 0) ? 1'($urandom % 2) : 1'b1;
      bus_rdata = (rfifo_q.size() > 0) ? rfifo_q[0] : 16'h0;
      #1;
      if (rst_n) begin
        wr = !wr_stb_n;
        rd = !rd_stb_n;
        if (s_ready != wr) check(0, "R9 s_ready vs strobe", int'(s_ready), int'(wr));
        if (wr) begin
          check(wcnt < DEPTH, "R4 write into full slave", wcnt, DEPTH - 1);
          check(bus_drive && s_valid, "R9 write without source/drive", int'(bus_drive), 1);
          if (wexp_q.size() > 0) check(bus_wdata == wexp_q[0], "R2 write order", int'(bus_wdata), int'(wexp_q[0]));
          else check(0, "R2 unexpected write", int'(bus_wdata), 0);
          if (wexp_q.size() > 0) void'(wexp_q.pop_front());
          if (src_q.size() > 0) void'(src_q.pop_front());
          wcnt++;
          if (wcnt > max_wcnt) max_wcnt = wcnt;
          if (first_wr < 0) first_wr = cyc;
          last_wr = cyc;
          n_wr++;
        end
        if (rd) begin
          check(rfifo_q.size() > 0, "R5 read from empty slave", rfifo_q.size(), 1);
          check(!oe_n, "R3 read without output enable", int'(oe_n), 0);
          if (rfifo_q.size() > 0) void'(rfifo_q.pop_front());
          if (src_q.size() > 0) reads_with_src++;
        end
        if (wr && rd) check(0, "R8 both strobes low", 1, 0);
        if (bus_drive && !oe_n) check(0, "R8 drive with oe low", 1, 0);
        if (bus_drive && !prev_drive && !prev_oe_n) check(0, "R7 no turnaround", 1, 0);
        if (half_rate && prev_half && (wr || rd) && prev_fire) check(0, "R6 back-to-back strobe", 1, 0);
        if (prev_mv && !prev_mr) begin
          if (!m_valid || m_data != prev_md) check(0, "R10 sink word not held", int'(m_data), int'(prev_md));
        end
        if (m_valid && m_ready) begin
          if (rexp_q.size() > 0) begin
            check(m_data == rexp_q[0], "R3 read order", int'(m_data), int'(rexp_q[0]));
            void'(rexp_q.pop_front());
          end else check(0, "R3 unexpected sink word", int'(m_data), 0);
        end
        wr_streak = wr ? wr_streak + 1 : 0;
        rd_streak = rd ? rd_streak + 1 : 0;
        if (wr_streak > max_wr_streak) max_wr_streak = wr_streak;
        if (rd_streak > max_rd_streak) max_rd_streak = rd_streak;
        if (wcnt > 0 && (cyc % drain_per) == 0) wcnt--;
        if (host_q.size() > 0 && rfifo_q.size() < DEPTH && (cyc % fill_per) == 0)
          rfifo_q.push_back(host_q.pop_front());
        prev_fire = wr || rd;
        prev_half = half_rate;
        prev_drive = bus_drive;
        prev_oe_n = oe_n;
        prev_mv = m_valid;
        prev_mr = m_ready;
        prev_md = m_data;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check(wr_stb_n && rd_stb_n, "R1 strobes in reset", int'({wr_stb_n, rd_stb_n}), 3);
    check(oe_n, "R1 oe in reset", int'(oe_n), 1);
    check(!bus_drive, "R1 drive in reset", int'(bus_drive), 0);
    check(!m_valid, "R1 m_valid in reset", int'(m_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(wr_stb_n && rd_stb_n && oe_n && !bus_drive && !s_ready, "R1 first cycle after reset", 0, 0);

    // R11 + R2 + R3: both directions pending from idle, full rate
    clear_stats();
    for (int i = 0; i < 20; i++) push_write(16'h1000 + 16'(i));
    for (int i = 0; i < 12; i++) push_read(16'h2000 + 16'(i));
    wait_drained("R2 full-rate phase completes", 2000);
    check(reads_with_src == 0, "R11 read during write burst", reads_with_src, 0);
    check(max_wr_streak >= 20, "R2 one write per clock", max_wr_streak, 20);
    check(max_rd_streak >= 10, "R3 one read per clock", max_rd_streak, 10);

    // R4: slow drain pushes write side to the full boundary
    clear_stats();
    drain_per = 4;
    for (int i = 0; i < 30; i++) push_write(16'h3000 + 16'(i));
    wait_drained("R4 slow-drain writes complete", 3000);
    check(max_wcnt >= DEPTH - 1, "R4 boundary reached", max_wcnt, DEPTH - 1);
    drain_per = 1;
    repeat (20) @(negedge clk);

    // R5: slow fill, odd word count, lone last word
    clear_stats();
    fill_per = 3;
    for (int i = 0; i < 13; i++) push_read(16'h4000 + 16'(i));
    wait_drained("R5 all words incl. final read", 3000);
    fill_per = 1;

    // R7, R9, R10: mixed traffic with source gaps and sink stalls
    clear_stats();
    src_gap = 1;
    sink_rand = 1;
    for (int i = 0; i < 25; i++) begin
      push_write(16'h5000 + 16'(i));
      push_read(16'h6000 + 16'(i));
    end
    wait_drained("R9 mixed traffic completes", 4000);
    src_gap = 0;
    sink_rand = 0;

    // R6: conservative mode
    half_rate = 1'b1;
    repeat (2) @(negedge clk);
    clear_stats();
    for (int i = 0; i < 24; i++) push_write(16'h7000 + 16'(i));
    wait_drained("R6 half-rate writes complete", 2000);
    check(n_wr == 24, "R6 half-rate write count", n_wr, 24);
    check(last_wr - first_wr >= 2 * 23, "R6 half throughput", last_wr - first_wr, 46);
    check(max_wr_streak == 1, "R6 single-cycle strobes", max_wr_streak, 1);
    clear_stats();
    for (int i = 0; i < 24; i++) push_read(16'h8000 + 16'(i));
    wait_drained("R6 half-rate reads complete", 2000);
    check(max_rd_streak == 1, "R6 single-cycle read strobes", max_rd_streak, 1);
    half_rate = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule